// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block lets two processors pass 32-bit words to each other through eight independent message queues. Each queue is a small first-in first-out store, four words deep. All queues and all event state share one register window. A processor writes a queue's data register to post a word and reads the same register to take the oldest word. Each queue shows a full flag and a count of unread words in read-only registers.

Each of the two users has its own pending register and its own enable register. For every queue, the pending register holds two event bits. One records that a word has arrived. The other records that the queue has room for another word. Software clears pending bits by writing ones to them. Each user has one interrupt line, which is raised when any pending bit is set and its enable bit is also set.

The bus side is a single-cycle register port. Read data is combinational from the address. A write, or the pop caused by a read, takes effect on the next rising clock edge.

Top module: `mbx_top`

Register map (byte addresses, 32-bit registers):

| Address | Register |
|---|---|
| 0x020 + 4u | pending register of user u |
| 0x060 + 4u | enable register of user u |
| 0x100 + 4q | status of queue q |
| 0x140 + 4q | unread count of queue q |
| 0x180 + 4q | data of queue q |

Addresses that are not in this table read as zero. Writes to them are ignored.

## Requirements
- R1: While the reset is asserted, all pending bits, all enable bits, all queue counts and both interrupt outputs are 0.
- R2: A word written to queue q's data register (0x180+4q) is returned unchanged by a later read of that register. Up to four words are returned in the order they were written. Each read of a non-empty queue removes one word.
- R3: Bit 0 of queue q's status register (0x100+4q) reads 1 when the queue holds four words and 0 otherwise. Bits 31:1 read as zero.
- R4: Queue q's count register (0x140+4q) returns the number of unread words, 0 to 4, in bits 2:0. The upper bits read as zero.
- R5: A write to a full queue is dropped. The count stays at 4 and the stored words and their order are unchanged.
- R6: A read of an empty queue's data register returns 0 and leaves the count at 0.
- R7: Bit 2q of each user's pending register is set on the clock edge at which a word is accepted into queue q.
- R8: Bit 2q+1 of each user's pending register is set on every clock edge at which queue q is not full. After the edges that follow reset, it therefore reads 1 for an empty queue. Once cleared, it stays 0 while the queue is full.
- R9: Writing a 1 to a pending bit clears it, and writing 0 leaves it unchanged. Each user's pending register is cleared only through its own address.
- R10: When a bit's set condition and a write-one-to-clear of that bit fall on the same clock edge, the bit ends up set.
- R11: User u's enable register (0x060+4u) reads back what was written, in bits 15:0. irq_o[u] is high exactly when some bit is set in both user u's pending register and user u's enable register.
- R12: Pushing to or popping from one queue changes neither the count nor the full flag of any other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| irq_o | output | 2 | One interrupt line per user |

## Verification
The bench fills one queue to four words and then writes a fifth word. A design that accepted the fifth word would wrap its write pointer and overwrite the oldest word, which the following ordered reads would expose.

The bench reads an empty queue. A design without an underflow guard would return stale data or let the count wrap to 7.

The bench clears the room-available bit of a non-full queue and expects it to stay set. It clears the same bit on a full queue and expects it to stay clear. A design that gave the clear priority, or that set the bit whenever the queue was written, fails one of these two checks.

The bench writes zero to a pending register, and clears one user's pending register while watching the other user's. These checks catch clears that are not masked by the written ones or that reach the wrong user. Interrupt checks with only one enabled bit catch a line that ignores the enable mask.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W    = 12;
  localparam int PEND_BASE = 'h020;
  localparam int EN_BASE   = 'h060;
  localparam int STAT_BASE = 'h100;
  localparam int CNT_BASE  = 'h140;
  localparam int MSG_BASE  = 'h180;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_CNT,
    SEL_MSG,
    SEL_PEND,
    SEL_EN
  } reg_sel_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NQ  = 8,
  parameter int NU  = 2,
  parameter int QIW = 3,
  parameter int UIW = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [QIW-1:0]    qidx_o,
  output logic [UIW-1:0]    uidx_o
);
  localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] STAT_HI = ADDR_W'(STAT_BASE + 4 * NQ);
  localparam logic [ADDR_W-1:0] CNT_LO  = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] CNT_HI  = ADDR_W'(CNT_BASE + 4 * NQ);
  localparam logic [ADDR_W-1:0] MSG_LO  = ADDR_W'(MSG_BASE);
  localparam logic [ADDR_W-1:0] MSG_HI  = ADDR_W'(MSG_BASE + 4 * NQ);
  localparam logic [ADDR_W-1:0] PEND_LO = ADDR_W'(PEND_BASE);
  localparam logic [ADDR_W-1:0] PEND_HI = ADDR_W'(PEND_BASE + 4 * NU);
  localparam logic [ADDR_W-1:0] EN_LO   = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI   = ADDR_W'(EN_BASE + 4 * NU);

  logic [ADDR_W-1:0] off;

  always_comb begin
    sel_o  = SEL_NONE;
    off    = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i >= STAT_LO && addr_i < STAT_HI) begin
        sel_o = SEL_STAT;
        off   = addr_i - STAT_LO;
      end else if (addr_i >= CNT_LO && addr_i < CNT_HI) begin
        sel_o = SEL_CNT;
        off   = addr_i - CNT_LO;
      end else if (addr_i >= MSG_LO && addr_i < MSG_HI) begin
        sel_o = SEL_MSG;
        off   = addr_i - MSG_LO;
      end else if (addr_i >= PEND_LO && addr_i < PEND_HI) begin
        sel_o = SEL_PEND;
        off   = addr_i - PEND_LO;
      end else if (addr_i >= EN_LO && addr_i < EN_HI) begin
        sel_o = SEL_EN;
        off   = addr_i - EN_LO;
      end
    end
  end

  assign qidx_o = QIW'(off >> 2);
  assign uidx_o = UIW'(off >> 2);
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PTW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          pushed_o
);
  localparam logic [CW-1:0]  CNT_MAX = CW'(DEPTH);
  localparam logic [PTW-1:0] PTR_MAX = PTW'(DEPTH - 1);

  logic [DW-1:0]  mem_q [DEPTH];
  logic [PTW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  cnt_q;
  logic           push_ok, pop_ok;

  assign full_o   = (cnt_q == CNT_MAX);
  assign push_ok  = push_i && !full_o;
  assign pop_ok   = pop_i && (cnt_q != '0);
  assign pushed_o = push_ok;
  assign count_o  = cnt_q;
  assign head_o   = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_ptr_q] <= wdata_i;
        wr_ptr_q <= (wr_ptr_q == PTR_MAX) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_ok) rd_ptr_q <= (rd_ptr_q == PTR_MAX) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R4
  count_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_MAX);
  // R5
  drop_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_o == CNT_MAX) && $stable(head_o));
  // R6
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_o == '0 && !push_i) |=> count_o == '0);
  // R2
  push_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> count_o == $past(count_o) + 1'b1);
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] set_i,
  input  logic [PW-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [PW-1:0] en_wdata_i,
  output logic [PW-1:0] pend_o,
  output logic [PW-1:0] en_o,
  output logic          irq_o
);
  logic [PW-1:0] pend_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;  // set dominates clear
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

  // R7
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
  // R9
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0 && set_i == '0) |=> $stable(pend_o));
  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int NU    = 2,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = 2 * NQ,
  localparam int QIW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int UIW  = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NU-1:0]     irq_o
);
  reg_sel_e       sel;
  logic [QIW-1:0] qidx;
  logic [UIW-1:0] uidx;

  logic [DW-1:0]  head  [NQ];
  logic [CW-1:0]  cnt   [NQ];
  logic [NQ-1:0]  full, pushed, push, pop;
  logic [PW-1:0]  set_vec;
  logic [PW-1:0]  pend  [NU];
  logic [PW-1:0]  en    [NU];

  logic wr_acc, rd_acc;
  assign wr_acc = req_i && we_i;
  assign rd_acc = req_i && !we_i;

  mbx_decode #(.NQ(NQ), .NU(NU), .QIW(QIW), .UIW(UIW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .qidx_o (qidx),
    .uidx_o (uidx)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign push[q] = wr_acc && (sel == SEL_MSG) && (qidx == QIW'(q));
    assign pop[q]  = rd_acc && (sel == SEL_MSG) && (qidx == QIW'(q));

    mbx_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (push[q]),
      .pop_i    (pop[q]),
      .wdata_i  (wdata_i),
      .head_o   (head[q]),
      .count_o  (cnt[q]),
      .full_o   (full[q]),
      .pushed_o (pushed[q])
    );

    assign set_vec[2*q]   = pushed[q];
    assign set_vec[2*q+1] = !full[q];
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    logic          sel_me;
    logic [PW-1:0] clr;
    assign sel_me = (uidx == UIW'(u));
    assign clr    = (wr_acc && sel == SEL_PEND && sel_me) ? wdata_i[PW-1:0] : '0;

    mbx_user_irq #(.PW(PW)) u_irq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_vec),
      .clr_i      (clr),
      .en_we_i    (wr_acc && sel == SEL_EN && sel_me),
      .en_wdata_i (wdata_i[PW-1:0]),
      .pend_o     (pend[u]),
      .en_o       (en[u]),
      .irq_o      (irq_o[u])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_STAT: rdata_o[0] = full[qidx];
      SEL_CNT:  rdata_o[CW-1:0] = cnt[qidx];
      SEL_MSG:  if (cnt[qidx] != '0) rdata_o = head[qidx];
      SEL_PEND: rdata_o[PW-1:0] = pend[uidx];
      SEL_EN:   rdata_o[PW-1:0] = en[uidx];
      default:  rdata_o = '0;
    endcase
  end

  // R12
  one_queue_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(push | pop) <= 1);
  // R1
  reset_irq_chk: assert property (@(posedge clk_i) !rst_ni |-> irq_o == '0);
endmodule

// File: tb/sim_mbx_top.sv
module sim_mbx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  mbx_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {we, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h18C, 32'hA000_0001, 32'h0},
    {1'b1, 12'h18C, 32'hA000_0002, 32'h0},
    {1'b1, 12'h18C, 32'hA000_0003, 32'h0},
    {1'b1, 12'h18C, 32'hA000_0004, 32'h0},
    {1'b0, 12'h10C, 32'h0, 32'h1},           // R3 full
    {1'b0, 12'h14C, 32'h0, 32'h4},           // R4
    {1'b1, 12'h18C, 32'hDEAD_BEEF, 32'h0},   // R5 dropped
    {1'b0, 12'h14C, 32'h0, 32'h4},           // R5
    {1'b0, 12'h11C, 32'h0, 32'h0},           // R12 other queue
    {1'b0, 12'h18C, 32'h0, 32'hA000_0001},   // R2 order
    {1'b0, 12'h10C, 32'h0, 32'h0},           // R3
    {1'b0, 12'h14C, 32'h0, 32'h3},           // R4
    {1'b0, 12'h18C, 32'h0, 32'hA000_0002},
    {1'b0, 12'h18C, 32'h0, 32'hA000_0003},
    {1'b0, 12'h18C, 32'h0, 32'hA000_0004},
    {1'b0, 12'h14C, 32'h0, 32'h0},
    {1'b0, 12'h18C, 32'h0, 32'h0},           // R6 empty read
    {1'b0, 12'h14C, 32'h0, 32'h0},           // R6
    {1'b0, 12'h140, 32'h0, 32'h0},           // R12
    {1'b0, 12'h100, 32'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    // R1 reset state, observed while reset is held
    repeat (3) @(negedge clk);
    addr = 12'h020; #1 chk("R1 pend0", rdata, 32'h0);
    addr = 12'h064; #1 chk("R1 en1", rdata, 32'h0);
    addr = 12'h154; #1 chk("R1 count q5", rdata, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 room bits set for all empty queues
    rd(12'h020, r); chk("R8 pend0", r, 32'h0000_AAAA);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], r);
        chk($sformatf("R2 vec%0d", i), r, VEC[i][31:0]);
      end
    end

    // R7 arrival bit of queue 3 (bit 6) in both users
    rd(12'h020, r); chk("R7 pend0", r, 32'h0000_AAEA);
    rd(12'h024, r); chk("R7 pend1", r, 32'h0000_AAEA);
    wr(12'h020, 32'h0000_0040);
    rd(12'h020, r); chk("R9 w1c", r, 32'h0000_AAAA);
    rd(12'h024, r); chk("R9 other user", r, 32'h0000_AAEA);

    // R9 zero write has no effect
    wr(12'h188, 32'h1234_5678);
    wr(12'h020, 32'h0);
    rd(12'h020, r); chk("R9 zero write", r, 32'h0000_AABA);
    // R10 room bits of non-full queues survive a clear
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, r); chk("R10 set wins", r, 32'h0000_AAAA);
    rd(12'h188, r); chk("R2 q2 data", r, 32'h1234_5678);

    // R8 room bit stays clear while full
    for (int k = 0; k < 4; k++) wr(12'h198, 32'h600 + k);
    rd(12'h118, r); chk("R3 q6 full", r, 32'h1);
    wr(12'h020, 32'h0000_2000);
    rd(12'h020, r); chk("R8 full clear", r, 32'h0000_9AAA);
    rd(12'h198, r); chk("R2 q6 head", r, 32'h600);
    rd(12'h020, r); chk("R8 room back", r, 32'h0000_BAAA);
    for (int k = 1; k < 4; k++) begin
      rd(12'h198, r); chk("R2 q6 drain", r, 32'h600 + k);
    end

    // R11 enable and interrupt
    wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h064, 32'h0000_0400);
    rd(12'h064, r); chk("R11 en readback", r, 32'h0000_0400);
    chk("R11 irq idle", {30'h0, irq}, 32'h0);
    wr(12'h194, 32'hCAFE_0005);
    chk("R11 irq raised", {30'h0, irq}, 32'h2);
    wr(12'h024, 32'h0000_0400);
    chk("R11 irq cleared", {30'h0, irq}, 32'h0);
    rd(12'h154, r); chk("R4 q5 count", r, 32'h1);
    rd(12'h194, r); chk("R2 q5 data", r, 32'hCAFE_0005);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule